// File: doc/BRIEF.md
# ADC Conversion Read Controller

This block sits on the host side of a serial link to a 16-bit successive-approximation converter. A one-cycle `start` request makes it assert an active-low select line, wait a configurable setup interval, and then drive 24 serial clock cycles in clock-polarity-0 / clock-phase-0 form. The clock idles low. The clock half period is a programmable number of system clocks, so the duty cycle is always 50 %. The converter changes its data line on falling serial clock edges. The controller therefore captures one bit on each rising edge, most significant bit first.

The 24 captured bits form three bytes. The first byte must be zero and is only checked, never kept. The second byte holds result bits 15..8 and the third holds bits 7..0. After the 24th falling edge the select line rises at once, the 16-bit result is presented with a one-cycle strobe, and a deselect interval is held before the next start can be accepted. A nonzero leading byte sets a sticky framing flag. An abort input ends any transfer at once, gives no result, and still enforces the deselect interval.

Divider ratio, setup interval and deselect interval are parameters counted in system clocks. They are checked at elaboration against the link's minimum timing, using the system clock period given by a further parameter.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset `cs_n` is 1, and `sclk`, `valid`, `frame_err` and `busy` are 0.
- R2: A `start` seen while idle drives `cs_n` low on the next clock edge. The transaction then carries exactly 24 rising `sclk` edges. `sclk` is low whenever `cs_n` is high.
- R3: In each `sclk` cycle of a transaction, the high phase and the low phase each last exactly DIV_HALF system clocks.
- R4: The first rising `sclk` edge comes exactly SETUP_CYC + DIV_HALF system clocks after `cs_n` falls.
- R5: The bit on `sdi` is captured at each rising `sclk` edge, first bit most significant. `result` is the last 16 of the 24 captured bits. `valid` is a one-cycle pulse in the same cycle that `cs_n` rises.
- R6: `cs_n` rises on the same clock edge that produces the 24th falling `sclk` edge.
- R7: After `cs_n` rises, `busy` stays high for exactly DESEL_CYC cycles. With `start` held high, `cs_n` stays high for exactly DESEL_CYC + 1 cycles before falling again.
- R8: If any of the first 8 captured bits is 1, `frame_err` becomes 1 in the cycle `valid` pulses and stays 1 until reset. `result` is still delivered.
- R9: `abort` during a transaction raises `cs_n` and forces `sclk` low on the next edge, without any `valid` pulse. This holds even on the edge that would end the frame. `busy` then stays high for DESEL_CYC cycles.
- R10: A `start` that arrives while `busy` is high is ignored. It neither disturbs the running transfer nor queues a new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one conversion read (accepted only when idle) |
| abort | input | 1 | Cancel the running transaction |
| sdi | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low converter select |
| busy | output | 1 | High from accepted start until deselect interval ends |
| result | output | DATA_W (16) | Last received conversion value |
| valid | output | 1 | One-cycle strobe marking a new `result` |
| frame_err | output | 1 | Sticky flag: a leading bit was nonzero |

## Verification
A wrong bit or half-period counter shows up as a wrong number of `sclk` rises, or as an uneven high or low phase. It is visible inside the same transaction, and at the latest when `cs_n` rises, about 24 serial clocks after start. A wrong shift position or byte boundary gives a result that is off by a shift, or a framing flag on a clean frame. Walking-one sweeps over both the data bytes and the leading byte make either fault visible on the first pattern it touches. A phase-sequencer fault makes the setup or deselect interval longer or shorter, or lets an abort still produce `valid`. Each of these is measured in system clocks within one transaction.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_XFER  = 2'd2,
    ST_DESEL = 2'd3
  } rd_state_t;

  // Minimum link timing in nanoseconds.
  localparam int MIN_HALF_NS   = 65;
  localparam int MIN_PERIOD_NS = 208;
  localparam int MAX_PERIOD_NS = 10000;  // keeps the serial clock at or above 100 kHz
  localparam int MIN_SETUP_NS  = 100;
  localparam int MIN_DESEL_NS  = 50;

  function automatic int sclk_period_ns(input int clk_ns, input int div_half);
    return 2 * div_half * clk_ns;
  endfunction

  function automatic bit timing_ok(input int clk_ns, input int div_half,
                                   input int setup_cyc, input int desel_cyc);
    int per;
    per = sclk_period_ns(clk_ns, div_half);
    return (div_half >= 1) && (setup_cyc >= 1) && (desel_cyc >= 1) &&
           (div_half * clk_ns >= MIN_HALF_NS) &&
           (per >= MIN_PERIOD_NS) && (per <= MAX_PERIOD_NS) &&
           (setup_cyc * clk_ns >= MIN_SETUP_NS) &&
           (desel_cyc * clk_ns >= MIN_DESEL_NS);
  endfunction

endpackage

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
  parameter int DIV_HALF = 11,
  parameter int HALVES   = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_now,
  output logic last_fall
);
  localparam int DW = $clog2(DIV_HALF + 1);
  localparam int HW = $clog2(HALVES + 1);

  logic [DW-1:0] div_q;
  logic [HW-1:0] half_q;
  logic          div_end;

  assign div_end   = run && (div_q == DW'(DIV_HALF - 1));
  assign rise_now  = div_end && !sclk;
  assign last_fall = div_end && sclk && (half_q == HW'(HALVES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      half_q <= '0;
      sclk   <= 1'b0;
    end else if (!run) begin
      div_q  <= '0;
      half_q <= '0;
      sclk   <= 1'b0;
    end else if (div_end) begin
      div_q  <= '0;
      half_q <= half_q + 1'b1;
      sclk   <= ~sclk;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end

  // Length of the current high phase, for the checker below.
  logic [DW:0] hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hi_run <= '0;
    else if (sclk) hi_run <= hi_run + 1'b1;
    else           hi_run <= '0;
  end

  // R3
  half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk) && $past(run)) |-> (hi_run == (DW+1)'(DIV_HALF)));

endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (en)  q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
  parameter int CLK_NS    = 10,
  parameter int DIV_HALF  = 11,
  parameter int SETUP_CYC = 10,
  parameter int DESEL_CYC = 5,
  parameter int DATA_W    = 16,
  parameter int LEAD_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              sdi,
  output logic              sclk,
  output logic              cs_n,
  output logic              busy,
  output logic [DATA_W-1:0] result,
  output logic              valid,
  output logic              frame_err
);
  import adc_rd_pkg::*;

  localparam int FRAME_W = DATA_W + LEAD_W;
  localparam int HALVES  = 2 * FRAME_W;
  localparam int TMAX    = (SETUP_CYC > DESEL_CYC) ? SETUP_CYC : DESEL_CYC;
  localparam int TW      = $clog2(TMAX + 1);

  if (!timing_ok(CLK_NS, DIV_HALF, SETUP_CYC, DESEL_CYC)) begin : g_timing_bad
    $error("adc_rd_ctrl: divider, setup or deselect parameters violate link timing");
  end

  rd_state_t          state;
  logic [TW-1:0]      tcnt;
  logic [FRAME_W-1:0] rx_word;

  // Named internal events.
  logic run, rise_now, frame_end, setup_done, desel_done, accept, lead_bad;

  assign busy       = (state != ST_IDLE);
  assign accept     = (state == ST_IDLE) && start;
  assign run        = (state == ST_XFER) && !abort;
  assign setup_done = (tcnt == TW'(SETUP_CYC - 1));
  assign desel_done = (tcnt == TW'(DESEL_CYC - 1));
  assign lead_bad   = |rx_word[FRAME_W-1:DATA_W];

  adc_rd_sclk_gen #(.DIV_HALF(DIV_HALF), .HALVES(HALVES)) u_sclk (
    .clk(clk), .rst_n(rst_n), .run(run),
    .sclk(sclk), .rise_now(rise_now), .last_fall(frame_end)
  );

  adc_rd_shift #(.W(FRAME_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(rise_now), .din(sdi), .q(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cs_n      <= 1'b1;
      tcnt      <= '0;
      valid     <= 1'b0;
      result    <= '0;
      frame_err <= 1'b0;
    end else begin
      valid <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_SETUP;
          cs_n  <= 1'b0;
          tcnt  <= '0;
        end
        ST_SETUP: if (abort) begin
          state <= ST_DESEL;
          cs_n  <= 1'b1;
          tcnt  <= '0;
        end else if (setup_done) begin
          state <= ST_XFER;
          tcnt  <= '0;
        end else begin
          tcnt  <= tcnt + 1'b1;
        end
        ST_XFER: if (abort) begin
          state <= ST_DESEL;
          cs_n  <= 1'b1;
          tcnt  <= '0;
        end else if (frame_end) begin
          state  <= ST_DESEL;
          cs_n   <= 1'b1;
          tcnt   <= '0;
          valid  <= 1'b1;
          result <= rx_word[DATA_W-1:0];
          if (lead_bad) frame_err <= 1'b1;
        end
        ST_DESEL: if (desel_done) state <= ST_IDLE;
                  else            tcnt  <= tcnt + 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checker-side interval counters.
  logic [15:0] lo_len, hi_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_len <= '0;
      hi_len <= '1;
    end else begin
      lo_len <= cs_n ? '0 : ((lo_len == '1) ? lo_len : lo_len + 1'b1);
      hi_len <= !cs_n ? '0 : ((hi_len == '1) ? hi_len : hi_len + 1'b1);
    end
  end

  // R2
  idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R4
  setup_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (int'(lo_len) >= SETUP_CYC));

  // R7
  deselect_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (int'(hi_len) >= DESEL_CYC));

  // R5
  valid_at_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $rose(cs_n));

  // R8
  frame_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_err) |-> frame_err);

  // R9
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(abort) && $past(busy)) |-> (cs_n && !sclk && !valid));

endmodule

// File: tb/adc_rd_ctrl_test.sv
module adc_rd_ctrl_test;
  localparam int D = 11;   // DIV_HALF
  localparam int S = 10;   // SETUP_CYC
  localparam int Q = 5;    // DESEL_CYC

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, abort = 1'b0, sdi = 1'b0;
  logic sclk, cs_n, busy, valid, frame_err;
  logic [15:0] result;

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;
  bit  exp_fe = 0;
  logic [23:0] frame = '0;

  always #5 clk = ~clk;

  adc_rd_ctrl #(.CLK_NS(10), .DIV_HALF(D), .SETUP_CYC(S), .DESEL_CYC(Q)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .sdi(sdi),
    .sclk(sclk), .cs_n(cs_n), .busy(busy), .result(result), .valid(valid),
    .frame_err(frame_err)
  );

  // Converter model: first bit after select falls, next bit on each falling sclk.
  initial begin
    int bi;
    forever begin
      @(negedge cs_n);
      bi  = 23;
      sdi = frame[23];
      while (!cs_n) begin
        @(negedge sclk or posedge cs_n);
        bi  = bi - 1;
        sdi = (!cs_n && bi >= 0) ? frame[bi] : 1'b0;
      end
      sdi = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; abort = 1'b0; exp_fe = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(cs_n == 1'b1, "R1", "cs_n after reset", cs_n, 1);
    chk({sclk, valid, frame_err, busy} == 4'b0, "R1", "sclk/valid/frame_err/busy after reset",
        {sclk, valid, frame_err, busy}, 0);
  endtask

  // Leaves the bench at the first sample after the start was accepted.
  task automatic launch(input logic [23:0] w);
    frame = w;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic measure(input logic [23:0] w, input int start_at);
    int run, rises, setup_m, bad_hi, bad_lo, guard;
    logic prev;
    bit first;
    run = 1; prev = 1'b0; first = 1; rises = 0; bad_hi = 0; bad_lo = 0;
    setup_m = -1; guard = 0;
    // R2
    chk(!cs_n && !sclk && busy, "R2", "select low after start", {cs_n, sclk, busy}, 3'b001);
    while (1) begin
      @(negedge clk);
      guard++;
      start = (guard == start_at);   // R10: stray start mid-transfer
      if (cs_n || guard > 3000) break;
      if (sclk == prev) run++;
      else begin
        if (prev == 1'b0) begin
          if (first) begin setup_m = run; first = 0; end
          else if (run != D) bad_lo++;
          rises++;
        end else if (run != D) bad_hi++;
        run = 1;
        prev = sclk;
      end
    end
    start = 1'b0;
    if (prev == 1'b1 && run != D) bad_hi++;
    chk(rises == 24, "R2", "rising sclk edges", rises, 24);
    chk(setup_m == S + D, "R4", "select to first rise", setup_m, S + D);
    chk(bad_hi == 0 && bad_lo == 0, "R3", "uneven sclk phases", bad_hi + bad_lo, 0);
    chk(prev == 1'b1 && !sclk && cs_n, "R6", "select rise with 24th fall", {prev, sclk, cs_n}, 3'b101);
    chk(valid == 1'b1, "R5", "valid at select rise", valid, 1);
    chk(result == w[15:0], "R5", "result", result, w[15:0]);
    if (|w[23:16]) exp_fe = 1;
    chk(frame_err == exp_fe, "R8", "framing flag", frame_err, exp_fe);
  endtask

  task automatic idle_wait(input int quiet);
    int n;
    bit vbad;
    n = 1; vbad = 0;
    while (1) begin
      @(negedge clk);
      if (valid) vbad = 1;
      if (!busy || n > 100) break;
      n++;
    end
    chk(!vbad, "R5", "valid wider than one cycle", vbad, 0);
    chk(n == Q, "R7", "busy cycles after select rise", n, Q);
    n = 0;
    for (int i = 0; i < quiet; i++) begin
      @(negedge clk);
      if (!cs_n || busy) n++;
    end
    chk(n == 0, "R10", "no transfer without a start", n, 0);
  endtask

  task automatic xfer(input logic [23:0] w);
    launch(w);
    measure(w, 0);
    idle_wait(4);
  endtask

  task automatic held_start(input logic [23:0] w1, input logic [23:0] w2);
    int n;
    launch(w1);
    measure(w1, 0);
    frame = w2;
    start = 1'b1;
    n = 1;
    while (1) begin
      @(negedge clk);
      if (!cs_n || n > 100) break;
      n++;
    end
    start = 1'b0;
    chk(n == Q + 1, "R7", "select high time with start held", n, Q + 1);
    measure(w2, 0);
    idle_wait(4);
  endtask

  task automatic abort_at(input int k, input logic [23:0] w);
    int n;
    bit vbad;
    launch(w);
    for (int i = 1; i < k; i++) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    // R9
    chk(cs_n && !sclk && !valid, "R9", "abort response", {cs_n, sclk, valid}, 3'b100);
    n = 1; vbad = 0;
    while (1) begin
      @(negedge clk);
      if (valid) vbad = 1;
      if (!busy || n > 100) break;
      n++;
    end
    chk(n == Q, "R9", "deselect after abort", n, Q);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (valid || !cs_n) vbad = 1;
    end
    chk(!vbad, "R9", "no result after abort", vbad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    for (int b = 0; b < 16; b++) xfer({8'h00, 16'(1 << b)});
    xfer(24'h000000);
    xfer(24'h00FFFF);
    xfer(24'h00A5A5);
    xfer(24'h005A5A);
    xfer(24'h008001);
    // R10: start pulsed in the middle of a transfer
    launch(24'h00C3E1);
    measure(24'h00C3E1, 100);
    idle_wait(60);
    held_start(24'h001357, 24'h00FEDC);
    abort_at(3, 24'h004444);
    xfer(24'h004444);
    abort_at(200, 24'h00BEEF);
    xfer(24'h00BEEF);
    abort_at(538, 24'h007777);   // lands on the frame-ending edge
    xfer(24'h007777);
    for (int b = 0; b < 8; b++) begin
      do_reset();
      xfer({8'(1 << b), 16'h1234});
      xfer(24'h000F0F);          // R8: flag stays set on a clean frame
    end
    do_reset();
    done = 1;
    summary();
    $finish;
  end
endmodule